// File: doc/BRIEF.md
# Byte-Wide EPROM Behavioural Model

A synthesizable stand-in for a byte-wide, UV-erasable programmable memory. It is meant for system-level verification where the real part would sit on a board. The model samples an address bus, an active-low chip enable, an active-low output enable, and two flags. One flag marks the presence of programming voltage. The other marks the identification voltage on address line 9. From these inputs it decodes one of eight operating modes. It drives or releases a data bus that is split into data-in, data-out and a drive enable. It commits programming pulses that can only clear bits. It also returns two fixed identifier bytes.

Storage depth is a parameter. The array starts erased (all ones), both after reset and after a single-cycle erase strobe. A program pulse is a stretch of clock cycles with chip enable low while output enable is high and programming voltage is present. The address and data of the pulse are captured while it is active. The write takes effect on the clock that first sees chip enable high again. Analog levels and access timings are not modelled.

Top module: `eprom_model`

## Requirements
- R1: After reset every location reads 0xFF.
- R2: With programming voltage absent, chip enable low, output enable low and the identification flag clear, data_oe_o is 1 and data_o equals the byte stored at addr_i.
- R3: With programming voltage absent and chip enable high, data_oe_o is 0 whatever output enable is.
- R4: With programming voltage absent, chip enable low and output enable high, data_oe_o is 0.
- R5: With programming voltage present, a pulse of one or more cycles with chip enable low and output enable high captures addr_i and data_i. On the first clock that sees chip enable high afterwards, the stored byte at that address becomes the old byte AND the captured data. Before that clock the stored byte is unchanged. If output enable goes low during the pulse, the pulse is cancelled and nothing is written.
- R6: With programming voltage present, chip enable high and output enable low (verify), data_oe_o is 1 and data_o is the stored byte.
- R7: With programming voltage present, chip enable low and output enable low (optional verify), data_oe_o is 1 and data_o is the stored byte.
- R8: With programming voltage present, chip enable high and output enable high (inhibit), data_oe_o is 0. Data applied during inhibit is never written.
- R9: With programming voltage absent, chip enable low, output enable low and the identification flag set, data_o is 0x20 when addr_i bit 0 is 0 and 0x04 when it is 1, with data_oe_o 1. If output enable is high, data_oe_o is 0. With programming voltage present the flag is ignored.
- R10: A one-cycle erase_i strobe sets every location to 0xFF from the next cycle on, and cancels a pending pulse.
- R11: Programming never turns a 0 bit into 1: programming 0xFF over a byte leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Model clock |
| rst_ni | input | 1 | Active-low asynchronous reset, erases the array |
| addr_i | input | AW | Address bus, AW = clog2(DEPTH) |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| vpp_hi_i | input | 1 | Programming voltage present |
| id_hi_i | input | 1 | Identification voltage on address line 9 |
| erase_i | input | 1 | Erase strobe, sets all bytes to 0xFF |
| data_i | input | DW | Data bus as seen by the model |
| data_o | output | DW | Data driven onto the bus (0 when released) |
| data_oe_o | output | 1 | Bus drive enable |

## Verification
The bench builds the model with DEPTH = 64. At that size every location can be programmed with a distinct pattern and read back in a short run, and the top address 63 is exercised as a boundary. Within the same run the bench covers repeated programming of one byte, which shows the AND accumulation. It also covers cancelled pulses, writes attempted under inhibit, both identifier bytes, and an erase that follows programmed content.

// File: rtl/eprom_pkg.sv
package eprom_pkg;
  typedef enum logic [2:0] {
    M_STANDBY, M_READ, M_OUT_OFF, M_SIG,
    M_PROG, M_VERIFY, M_VERIFY_ALT, M_INHIBIT
  } mode_e;

  localparam logic [7:0] MFR_CODE = 8'h20;
  localparam logic [7:0] DEV_CODE = 8'h04;
endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
  import eprom_pkg::*;
(
  input  logic  ce_ni,
  input  logic  oe_ni,
  input  logic  vpp_hi_i,
  input  logic  id_hi_i,
  output mode_e mode_o,
  output logic  drive_o
);
  always_comb begin
    if (vpp_hi_i) begin
      unique case ({ce_ni, oe_ni})
        2'b00:   mode_o = M_VERIFY_ALT;
        2'b01:   mode_o = M_PROG;
        2'b10:   mode_o = M_VERIFY;
        default: mode_o = M_INHIBIT;
      endcase
    end else if (ce_ni) begin
      mode_o = M_STANDBY;
    end else if (oe_ni) begin
      mode_o = M_OUT_OFF;
    end else if (id_hi_i) begin
      mode_o = M_SIG;
    end else begin
      mode_o = M_READ;
    end
  end

  always_comb begin
    unique case (mode_o)
      M_READ, M_SIG, M_VERIFY, M_VERIFY_ALT: drive_o = 1'b1;
      default:                               drive_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/eprom_prog_ctl.sv
module eprom_prog_ctl
  import eprom_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  mode_e         mode_i,
  input  logic          erase_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  logic          ce_q;
  logic          pend_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  // commit on the first cycle chip enable is seen high after a live pulse
  assign wr_en_o   = ce_ni && !ce_q && pend_q && !erase_i;
  assign wr_addr_o = addr_q;
  assign wr_data_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q   <= 1'b1;
      pend_q <= 1'b0;
      addr_q <= '0;
      data_q <= '1;
    end else begin
      ce_q <= ce_ni;
      if (erase_i) begin
        pend_q <= 1'b0;
      end else if (!ce_ni) begin
        // any non-program cycle inside the pulse cancels it
        pend_q <= (mode_i == M_PROG);
        if (mode_i == M_PROG) begin
          addr_q <= addr_i;
          data_q <= data_i;
        end
      end else if (wr_en_o) begin
        pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/eprom_array.sv
module eprom_array #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          erase_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[i] <= '1;
      end else if (erase_i) begin
        mem_q[i] <= '1;
      end else if (wr_en_i && (wr_addr_i == AW'(i))) begin
        mem_q[i] <= mem_q[i] & wr_data_i;  // cells only discharge
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/eprom_model.sv
module eprom_model
  import eprom_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          vpp_hi_i,
  input  logic          id_hi_i,
  input  logic          erase_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o
);
  mode_e         mode;
  logic          drive;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;

  eprom_mode_dec u_dec (
    .ce_ni    (ce_ni),
    .oe_ni    (oe_ni),
    .vpp_hi_i (vpp_hi_i),
    .id_hi_i  (id_hi_i),
    .mode_o   (mode),
    .drive_o  (drive)
  );

  eprom_prog_ctl #(.AW(AW), .DW(DW)) u_prog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_ni     (ce_ni),
    .mode_i    (mode),
    .erase_i   (erase_i),
    .addr_i    (addr_i),
    .data_i    (data_i),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data)
  );

  eprom_array #(.DEPTH(DEPTH), .DW(DW)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .erase_i   (erase_i),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (addr_i),
    .rd_data_o (rd_data)
  );

  always_comb begin
    data_oe_o = drive;
    if (!drive)             data_o = '0;
    else if (mode == M_SIG) data_o = DW'(addr_i[0] ? DEV_CODE : MFR_CODE);
    else                    data_o = rd_data;
  end
endmodule

// File: rtl/eprom_model_chk.sv
module eprom_model_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          ce_ni,
  input logic          oe_ni,
  input logic          vpp_hi_i,
  input logic          id_hi_i,
  input logic          erase_i,
  input logic [DW-1:0] data_o,
  input logic          data_oe_o
);
  logic past_ok_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  logic stored_rd;
  assign stored_rd = !oe_ni && (vpp_hi_i || (!ce_ni && !id_hi_i));

  p_read_drive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vpp_hi_i && !ce_ni && !oe_ni) |-> data_oe_o);
  p_standby_hiz_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vpp_hi_i && ce_ni) |-> !data_oe_o);
  p_out_off_hiz_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vpp_hi_i && !ce_ni && oe_ni) |-> !data_oe_o);
  p_verify_drive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vpp_hi_i && ce_ni && !oe_ni) |-> data_oe_o);
  p_alt_verify_drive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vpp_hi_i && !ce_ni && !oe_ni) |-> data_oe_o);
  p_inhibit_hiz_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vpp_hi_i && ce_ni && oe_ni) |-> !data_oe_o);
  p_sig_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vpp_hi_i && id_hi_i && !ce_ni && !oe_ni) |->
      (data_o == (addr_i[0] ? DW'(8'h04) : DW'(8'h20))));
  p_erase_blank_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && $past(erase_i) && stored_rd) |-> (data_o == '1));
  p_clear_only_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && stored_rd && $past(stored_rd) && !$past(erase_i) &&
     (addr_i == $past(addr_i))) |-> ((data_o & ~$past(data_o)) == '0));
endmodule

bind eprom_model eprom_model_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/tb_eprom_model.sv
`timescale 1ns/1ps
module tb_eprom_model;
  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH);
  localparam int DW    = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          ce_ni = 1'b1, oe_ni = 1'b1, vpp_hi_i = 1'b0, id_hi_i = 1'b0, erase_i = 1'b0;
  logic [DW-1:0] data_i = '1;
  logic [DW-1:0] data_o;
  logic          data_oe_o;

  int  n_cmp = 0, n_bad = 0;
  bit  done = 0;
  int  ref_mem [DEPTH];
  bit  pend = 0, ce_prev = 1;
  int  laddr = 0, ldat = 0;

  always #2.5 clk_i = ~clk_i;

  eprom_model #(.DEPTH(DEPTH), .DW(DW)) dut (.*);

  task automatic cyc(input bit ce, input bit oe, input bit vpp, input bit id,
                     input bit er, input int a, input int d, input string tag);
    bit exp_oe;
    int exp_d;
    @(negedge clk_i);
    ce_ni = ce; oe_ni = oe; vpp_hi_i = vpp; id_hi_i = id; erase_i = er;
    addr_i = AW'(a); data_i = DW'(d);
    #1;
    exp_oe = 0; exp_d = 0;
    if (vpp) begin
      if (!oe) begin exp_oe = 1; exp_d = ref_mem[a]; end
    end else if (!ce && !oe) begin
      exp_oe = 1;
      exp_d  = id ? ((a % 2) ? 8'h04 : 8'h20) : ref_mem[a];
    end
    n_cmp++;
    if (data_oe_o !== exp_oe || (exp_oe && data_o !== DW'(exp_d))) begin
      n_bad++;
      $display("FAIL %s addr=%0d: actual oe=%0b data=%02h expected oe=%0b data=%02h",
               tag, a, data_oe_o, data_o, exp_oe, exp_d);
    end
    @(posedge clk_i);
    if (er) begin
      foreach (ref_mem[i]) ref_mem[i] = 8'hFF;
      pend = 0;
    end else begin
      if (ce && !ce_prev && pend) begin
        ref_mem[laddr] = ref_mem[laddr] & ldat;
        pend = 0;
      end
      if (!ce) begin
        pend = vpp && oe;
        if (pend) begin laddr = a; ldat = d; end
      end
    end
    ce_prev = ce;
  endtask

  task automatic pulse(input int a, input int d, input int len, input string tag);
    for (int k = 0; k < len; k++) cyc(0, 1, 1, 0, 0, a, d, tag);
    cyc(1, 1, 1, 0, 0, a, 8'h00, tag);  // rising edge: commit happens here
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    foreach (ref_mem[i]) ref_mem[i] = 8'hFF;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1: erased after reset
    for (int a = 0; a < DEPTH; a += 9) cyc(0, 0, 0, 0, 0, a, 0, "R1");
    cyc(0, 0, 0, 0, 0, DEPTH-1, 0, "R1");

    // R5: stored byte unchanged during pulse, updated after chip enable rises
    cyc(0, 1, 1, 0, 0, 3, 8'hA5, "R5");
    cyc(0, 0, 1, 0, 0, 3, 8'hA5, "R5");   // optional verify cancels pulse
    cyc(1, 0, 1, 0, 0, 3, 8'h00, "R5");   // no write, still FF
    pulse(3, 8'hA5, 2, "R5");
    cyc(1, 0, 1, 0, 0, 3, 0, "R6");       // verify
    cyc(0, 0, 1, 0, 0, 3, 0, "R7");       // optional verify
    // R11: AND accumulation and no 0->1
    pulse(3, 8'h0F, 1, "R11");
    cyc(1, 0, 1, 0, 0, 3, 0, "R11");
    pulse(3, 8'hFF, 3, "R11");
    cyc(1, 0, 1, 0, 0, 3, 0, "R11");

    // R8: inhibit ignores data and never writes
    for (int k = 0; k < 4; k++) cyc(1, 1, 1, 0, 0, 3, 8'h00, "R8");
    cyc(1, 0, 1, 0, 0, 3, 0, "R8");

    // R2, R3, R4 with stored content
    cyc(0, 0, 0, 0, 0, 3, 0, "R2");
    cyc(1, 0, 0, 0, 0, 3, 0, "R3");
    cyc(1, 1, 0, 0, 0, 3, 0, "R3");
    cyc(0, 1, 0, 0, 0, 3, 0, "R4");

    // R9: identifier bytes, flag ignored under programming voltage
    cyc(0, 0, 0, 1, 0, 0, 0, "R9");
    cyc(0, 0, 0, 1, 0, 1, 0, "R9");
    cyc(0, 1, 0, 1, 0, 1, 0, "R9");
    cyc(1, 0, 1, 1, 0, 3, 0, "R9");

    // boundary: top address
    pulse(DEPTH-1, 8'h3C, 1, "R5");
    cyc(0, 0, 0, 0, 0, DEPTH-1, 0, "R2");

    // sweep distinct patterns over every location
    for (int a = 0; a < DEPTH; a++) pulse(a, (a * 37 + 5) & 8'hFF, 1 + a % 3, "R5");
    for (int a = 0; a < DEPTH; a++) cyc(0, 0, 0, 0, 0, a, 0, "R2");

    // R10: erase, including a pending pulse being dropped
    cyc(0, 1, 1, 0, 0, 7, 8'h00, "R10");
    cyc(0, 1, 1, 0, 1, 7, 8'h00, "R10");
    cyc(1, 1, 1, 0, 0, 7, 8'h00, "R10");
    for (int a = 0; a < DEPTH; a += 5) cyc(0, 0, 0, 0, 0, a, 0, "R10");
    cyc(1, 0, 1, 0, 0, 7, 0, "R10");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule